// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block turns a fast reference clock into a slow clock whose average frequency lies between two integer divisions of the reference. It counts reference cycles into output periods, and in dual mode runs a fixed number of periods at a first length, then a fixed number at a second length, and repeats that pattern. Spreading the two lengths this way gives a fractional average ratio. A 24 MHz crystal can therefore yield a 32768 Hz clock, which no single integer ratio produces.

Two 32-bit control words configure it. The divide word holds both period lengths, the dual-mode enable and two gate enables. The repeat word holds both repeat counts and a bypass enable. Reprogramming is done with both gates closed. Software then opens the input gate and, once the divider has settled, the output gate. In bypass the reference clock is passed straight through.

Top module: `frac_clk_div`

## Requirements
- R1: Every length and repeat field holds its value minus one. Divide word: first length in bits 11:0, second length in bits 23:12. Repeat word: first count in bits 11:0, second count in bits 23:12. A field of k means k+1 reference cycles or k+1 output periods.
- R2: With divide-word bit 28 clear (single mode), every output period lasts exactly first-length+1 reference cycles.
- R3: With bit 28 set (dual mode), the output gives first-count+1 periods of first-length+1 cycles, then second-count+1 periods of second-length+1 cycles, and this pattern repeats indefinitely.
- R4: Each output period of N cycles is high for its first floor(N/2) cycles and low for the rest.
- R5: With repeat-word bit 24 set, clk_out follows ref_clk undivided.
- R6: With divide-word bit 31 (input gate) clear, the counters stop and the output stays low. When the gate reopens, the pattern restarts at the start of the first-length phase.
- R7: With divide-word bit 30 (output gate) clear, clk_out is low from the second reference edge onward and stays low.
- R8: The output gate opens only at a period boundary, so the first pulse after opening has full length.
- R9: A change to the length or count fields while running takes effect only at the next pattern boundary. A full pattern already in progress finishes with the old values.
- R10: The synchronous active-high reset drives clk_out low and clears all counters and sequencer state.
- R11: Fields 732, 731, 7, 10 in dual mode give 19 periods per pattern totalling 13916 reference cycles, eight of them 733 cycles long. From 24 MHz this averages 32768 Hz within rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 32 | Divide word: lengths, dual enable, output gate, input gate |
| cfg_rep | input | 32 | Repeat word: repeat counts, bypass enable |
| clk_out | output | 1 | Divided clock, or ref_clk in bypass |

## Verification
Single-mode runs with even and odd lengths separate the period length from the high-time rule. Directed dual patterns with unequal lengths and counts show whether the phase switch happens after the right number of periods. A mid-pattern field change shows whether new values wait for the pattern boundary. Seeded random length and count sets, in both modes, cover ratios the directed cases miss. The 733/732 setting is checked by summing one whole pattern. Gate cases open the output mid-period and close it mid-pulse, and they stop the input mid-pattern to confirm the restart at the first phase.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int REG_W    = 32;
    localparam int FIELD_W  = 12;

    // divide word layout
    localparam int LEN_A_LSB  = 0;
    localparam int LEN_B_LSB  = 12;
    localparam int DUAL_BIT   = 28;
    localparam int OGATE_BIT  = 30;
    localparam int IGATE_BIT  = 31;

    // repeat word layout
    localparam int REP_A_LSB  = 0;
    localparam int REP_B_LSB  = 12;
    localparam int BYPASS_BIT = 24;

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef struct packed {
        field_t len_a;
        field_t len_b;
        field_t rep_a;
        field_t rep_b;
        logic   dual;
    } div_cfg_t;

    typedef struct packed {
        logic in_en;
        logic out_en;
        logic bypass;
    } gate_ctl_t;

    // number of high cycles for a period whose length field is fld:
    // floor((fld+1)/2)
    function automatic field_t high_len(input field_t fld);
        logic [FIELD_W:0] s;
        s = {1'b0, fld} + 1'b1;
        return s[FIELD_W:1];
    endfunction

endpackage

// File: rtl/fdiv_cfg_decode.sv
module fdiv_cfg_decode
    import fdiv_pkg::*;
(
    input  logic [REG_W-1:0] div_word,
    input  logic [REG_W-1:0] rep_word,
    output div_cfg_t         cfg,
    output gate_ctl_t        gates
);

    always_comb begin
        cfg.len_a  = div_word[LEN_A_LSB +: FIELD_W];
        cfg.len_b  = div_word[LEN_B_LSB +: FIELD_W];
        cfg.dual   = div_word[DUAL_BIT];
        cfg.rep_a  = rep_word[REP_A_LSB +: FIELD_W];
        cfg.rep_b  = rep_word[REP_B_LSB +: FIELD_W];
        gates.in_en  = div_word[IGATE_BIT];
        gates.out_en = div_word[OGATE_BIT];
        gates.bypass = rep_word[BYPASS_BIT];
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{div_word[27:24], div_word[29], rep_word[31:25]};

endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
    import fdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_en,
    input  logic     period_end,
    input  div_cfg_t live_cfg,
    output field_t   cur_len
);

    div_cfg_t sh;
    phase_e   phase;
    field_t   rep;
    logic     last_rep;
    logic     wrap;

    always_comb begin
        cur_len  = (phase == PH_B) ? sh.len_b : sh.len_a;
        last_rep = (rep == ((phase == PH_B) ? sh.rep_b : sh.rep_a));
        wrap     = period_end && (!sh.dual || (phase == PH_B && last_rep));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            phase <= PH_A;
            rep   <= '0;
        end else if (!in_en) begin
            sh    <= live_cfg;
            phase <= PH_A;
            rep   <= '0;
        end else if (period_end) begin
            if (wrap) begin
                sh    <= live_cfg;
                phase <= PH_A;
                rep   <= '0;
            end else if (last_rep) begin
                phase <= PH_B;
                rep   <= '0;
            end else begin
                rep   <= rep + 1'b1;
            end
        end
    end

    // R3: second phase is reachable only with dual mode latched
    p_second_needs_dual_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_B) |-> sh.dual);

    // R3: repeat counter never passes the count of its phase
    p_rep_range_r3: assert property (@(posedge clk) disable iff (rst)
        rep <= ((phase == PH_B) ? sh.rep_b : sh.rep_a));

    // R6: closed input gate returns the sequencer to the first phase
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> (phase == PH_A && rep == '0));

    // R9: latched configuration only moves at a pattern boundary
    p_cfg_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (in_en && !wrap) |=> $stable(sh));

endmodule

// File: rtl/fdiv_period_ctr.sv
module fdiv_period_ctr
    import fdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_en,
    input  field_t cur_len,
    output logic   period_end,
    output logic   hi
);

    field_t cnt;

    always_comb begin
        period_end = in_en && (cnt == cur_len);
        hi         = in_en && (cnt < high_len(cur_len));
    end

    always_ff @(posedge clk) begin
        if (rst || !in_en || period_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: counter stays inside the programmed length
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= cur_len);

    // R6: counter frozen at zero while the input gate is closed
    p_hold_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> (cnt == '0));

endmodule

// File: rtl/fdiv_out_stage.sv
module fdiv_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic out_en,
    input  logic bypass,
    input  logic period_end,
    input  logic hi,
    output logic clk_out
);

    logic out_open;
    logic q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_open <= 1'b0;
            q        <= 1'b0;
        end else begin
            out_open <= out_en && (out_open || period_end);
            q        <= hi && out_open;
        end
    end

    assign clk_out = bypass ? clk : q;

    // R7: cleared output gate closes the stage on the next edge
    p_close_r7: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> !out_open);

    // R7: a closed stage holds the divided output low
    p_low_closed_r7: assert property (@(posedge clk) disable iff (rst)
        !out_open |=> !q);

    // R8: the stage opens only as a period ends
    p_open_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_open) |-> $past(period_end));

    // R10: reset drives the divided output low
    p_reset_low_r10: assert property (@(posedge clk)
        rst |=> !q);

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fdiv_pkg::*;
(
    input  logic        ref_clk,
    input  logic        rst,
    input  logic [31:0] cfg_div,
    input  logic [31:0] cfg_rep,
    output logic        clk_out
);

    div_cfg_t  live_cfg;
    gate_ctl_t gates;
    field_t    cur_len;
    logic      period_end;
    logic      hi;

    fdiv_cfg_decode u_decode (
        .div_word (cfg_div),
        .rep_word (cfg_rep),
        .cfg      (live_cfg),
        .gates    (gates)
    );

    fdiv_seq u_seq (
        .clk        (ref_clk),
        .rst        (rst),
        .in_en      (gates.in_en),
        .period_end (period_end),
        .live_cfg   (live_cfg),
        .cur_len    (cur_len)
    );

    fdiv_period_ctr u_ctr (
        .clk        (ref_clk),
        .rst        (rst),
        .in_en      (gates.in_en),
        .cur_len    (cur_len),
        .period_end (period_end),
        .hi         (hi)
    );

    fdiv_out_stage u_out (
        .clk        (ref_clk),
        .rst        (rst),
        .out_en     (gates.out_en),
        .bypass     (gates.bypass),
        .period_end (period_end),
        .hi         (hi),
        .clk_out    (clk_out)
    );

endmodule

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_div = '0;
    logic [31:0] cfg_rep = '0;
    logic        clk_out;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc   = 0;

    always #2 clk = ~clk;   // 250 MHz

    frac_clk_div i_frac_clk_div (
        .ref_clk (clk),
        .rst     (rst),
        .cfg_div (cfg_div),
        .cfg_rep (cfg_rep),
        .clk_out (clk_out)
    );

    function automatic logic [31:0] w_div(int a, int b, bit dual, bit og, bit ig);
        logic [31:0] w;
        w = '0;
        w[11:0]  = a[11:0];
        w[23:12] = b[11:0];
        w[28] = dual;
        w[30] = og;
        w[31] = ig;
        return w;
    endfunction

    function automatic logic [31:0] w_rep(int a, int b, bit byp);
        logic [31:0] w;
        w = '0;
        w[11:0]  = a[11:0];
        w[23:12] = b[11:0];
        w[24] = byp;
        return w;
    endfunction

    // expected length of period k counted from the start of the pattern
    function automatic int exp_len(int k, int la, int lb, int ra, int rb, bit dual);
        int p;
        if (!dual) return la + 1;
        p = k % (ra + rb + 2);
        return (p <= ra) ? la + 1 : lb + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(output bit got);
        logic prev;
        prev = clk_out;
        got  = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!prev && clk_out) begin
                got = 1'b1;
                return;
            end
            prev = clk_out;
        end
    endtask

    // called at the sample where a rise was seen; returns at the next rise
    task automatic meas(output int len, output int hi_n);
        logic prev;
        prev = clk_out;
        len  = 1;
        hi_n = 1;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (!prev && clk_out) return;
            len++;
            if (clk_out) hi_n++;
            prev = clk_out;
        end
        len = -1;
    endtask

    task automatic prog(int la, int lb, int ra, int rb, bit dual);
        @(negedge clk);
        cfg_div = w_div(la, lb, dual, 1'b0, 1'b0);
        cfg_rep = w_rep(ra, rb, 1'b0);
        repeat (4) @(negedge clk);
        cfg_div = w_div(la, lb, dual, 1'b1, 1'b1);
    endtask

    task automatic run_check(string req, int la, int lb, int ra, int rb, bit dual,
                             int first_k, int count);
        bit got;
        int len, hn, e;
        wait_rise(got);
        chk(got, req, got, 1);
        if (!got) return;
        for (int k = first_k; k < first_k + count; k++) begin
            meas(len, hn);
            e = exp_len(k, la, lb, ra, rb, dual);
            chk(len == e, req, len, e);
            chk(hn == e / 2, "R4", hn, e / 2);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        bit got;
        int len, hn, hits, sum, n733;
        int la, lb, ra, rb, cnt;
        bit dual;
        int exp_r9 [6] = '{6, 6, 8, 8, 10, 10};
        void'($urandom(32'd2024));

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(clk_out == 1'b0, "R10", clk_out, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(clk_out == 1'b0, "R10", clk_out, 0);

        // R1 R2 R4: single mode, even and odd lengths
        prog(9, 0, 0, 0, 1'b0);
        run_check("R2", 9, 0, 0, 0, 1'b0, 1, 3);
        prog(6, 0, 0, 0, 1'b0);
        run_check("R1", 6, 0, 0, 0, 1'b0, 1, 3);

        // R3: directed dual pattern, two full rounds
        prog(4, 6, 1, 2, 1'b1);
        run_check("R3", 4, 6, 1, 2, 1'b1, 1, 10);

        // R6: input gate closed mid-pattern, then reopened
        @(negedge clk);
        cfg_div = w_div(4, 6, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk(clk_out == 1'b0, "R6", clk_out, 0);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_out) hits++;
        end
        chk(hits == 0, "R6", hits, 0);
        cfg_div = w_div(4, 6, 1'b1, 1'b1, 1'b1);
        run_check("R6", 4, 6, 1, 2, 1'b1, 0, 5);

        // R9: field change mid-pattern waits for the pattern boundary
        prog(3, 5, 1, 1, 1'b1);
        wait_rise(got);
        chk(got, "R9", got, 1);
        meas(len, hn);
        chk(len == 4, "R9", len, 4);
        cfg_div = w_div(7, 9, 1'b1, 1'b1, 1'b1);
        for (int j = 0; j < 6; j++) begin
            meas(len, hn);
            chk(len == exp_r9[j], "R9", len, exp_r9[j]);
        end

        // R8: output gate opened at an arbitrary point
        @(negedge clk);
        cfg_div = w_div(19, 0, 1'b0, 1'b0, 1'b0);
        cfg_rep = w_rep(0, 0, 1'b0);
        repeat (4) @(negedge clk);
        cfg_div = w_div(19, 0, 1'b0, 1'b0, 1'b1);
        cnt = 7 + int'($urandom % 24);
        hits = 0;
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            if (clk_out) hits++;
        end
        chk(hits == 0, "R8", hits, 0);
        cfg_div = w_div(19, 0, 1'b0, 1'b1, 1'b1);
        wait_rise(got);
        meas(len, hn);
        chk(hn == 10, "R8", hn, 10);
        chk(len == 20, "R8", len, 20);

        // R7: output gate cleared during a high phase
        while (!clk_out) @(negedge clk);
        cfg_div = w_div(19, 0, 1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk(clk_out == 1'b0, "R7", clk_out, 0);
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (clk_out) hits++;
        end
        chk(hits == 0, "R7", hits, 0);

        // R5: bypass passes the reference through
        cfg_rep = w_rep(0, 0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(clk_out == 1'b0, "R5", clk_out, 0);
            @(posedge clk);
            #1;
            chk(clk_out == 1'b1, "R5", clk_out, 1);
        end
        @(negedge clk);
        cfg_rep = '0;

        // random configurations, both modes
        for (int t = 0; t < 6; t++) begin
            la   = 1 + int'($urandom % 14);
            lb   = 1 + int'($urandom % 14);
            ra   = int'($urandom % 4);
            rb   = int'($urandom % 4);
            dual = 1'($urandom % 2);
            prog(la, lb, ra, rb, dual);
            run_check(dual ? "R3" : "R2", la, lb, ra, rb, dual, 1,
                      dual ? 2 * (ra + rb + 2) : 4);
        end

        // R11: 24 MHz to 32768 Hz setting, one whole pattern
        prog(732, 731, 7, 10, 1'b1);
        wait_rise(got);
        sum = 0;
        n733 = 0;
        for (int k = 0; k < 19; k++) begin
            meas(len, hn);
            sum += len;
            if (len == 733) n733++;
        end
        chk(sum == 13916, "R11", sum, 13916);
        chk(n733 == 8, "R11", n733, 8);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule